// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, a 16-bit segment selector paired with an offset, into a linear address. The selector's table-choice bit picks either the global or the local descriptor table base. The index field, scaled by eight, is added to that base to form the address of an 8-byte descriptor. The descriptor is fetched as two 32-bit words over a request/response memory port. A 32-bit segment base is assembled from scattered descriptor fields and added to the offset.

A mode input sets the address width to 32 or 64 bits. In 64-bit mode the sum is checked for canonical form, assuming 48 implemented linear bits, and a fault flag reports a failed check. Paging is not modelled, so the physical address output always equals the linear address. A caller presents a request while the block is idle and reads the results in the cycle that `done_o` pulses. The results then stay steady until the next request is accepted.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `done_o`, `mem_req_valid_o`, `fault_o` and `lin_addr_o` are all 0.
- R2: Selector bit 2 chooses the table base: 0 selects `gdt_base_i` and 1 selects `ldt_base_i`. Both bases are sampled when the request is accepted. The descriptor address is the chosen base plus selector bits 15:3 times 8. In 32-bit mode only the low 32 bits of this sum are kept, and the upper bits are zero.
- R3: Each translation makes exactly two memory reads. The first is at the descriptor address and the second is at that address plus 4, wrapping within 32 bits in 32-bit mode. A read is issued by holding `mem_req_valid_o` until `mem_req_ready_i` is seen. Its data is taken on the first `mem_rsp_valid_i` in a later cycle.
- R4: The segment base is assembled as follows. Bits 15:0 come from first-word bits 31:16. Bits 23:16 come from second-word bits 7:0. Bits 31:24 come from second-word bits 31:24. The upper bits of the base are zero.
- R5: In 32-bit mode (`mode64_i`=0), `lin_addr_o` is (base + offset[31:0]) mod 2^32, zero-extended. Offset bits 63:32 have no effect.
- R6: In 64-bit mode, `lin_addr_o` is the full 64-bit sum of the base and the offset, modulo 2^64.
- R7: `fault_o` is 1 only in 64-bit mode, and only when bits 63:47 of the linear address are not all equal. It is never set in 32-bit mode.
- R8: `phys_addr_o` always equals `lin_addr_o`.
- R9: `rpl_o` equals bits 1:0 of the accepted selector. These bits have no effect on the linear address.
- R10: `done_o` is high for exactly one cycle per translation, in the cycle after the second read's data arrives. `req_ready_o` is high only while idle. A request presented while the block is busy is ignored.
- R11: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| selector_i | input | 16 | Segment selector |
| offset_i | input | 64 | Offset (effective address) |
| mode64_i | input | 1 | 1 = 64-bit width with canonical check, 0 = 32-bit |
| gdt_base_i | input | 64 | Global descriptor table base |
| ldt_base_i | input | 64 | Local descriptor table base |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| lin_addr_o | output | 64 | Linear address |
| phys_addr_o | output | 64 | Physical address (equal to linear) |
| fault_o | output | 1 | Non-canonical result in 64-bit mode |
| rpl_o | output | 2 | Requested privilege level carried through |

## Verification
Pairs of selectors that differ only in the table bit, with distinct table bases, show whether the right base is used. Descriptor words with distinct bytes in every field expose any misplaced base slice. Offsets with nonzero upper halves and sums that overflow 32 bits separate 32-bit truncation from 64-bit addition. In 64-bit mode, sums just below 2^47, at 2^47 and in the upper canonical half pin down where the fault boundary lies. A stalling memory port, together with a request issued while the block is busy, shows that the address holds steady and that the pending translation is not disturbed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_LO = 2'd1,
    ST_READ_HI = 2'd2,
    ST_DONE    = 2'd3
  } fetch_state_e;

  // segment base scattered over the two descriptor words
  function automatic logic [31:0] seg_base(input logic [31:0] lo_w, input logic [31:0] hi_w);
    return {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
  endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 13,
  parameter int NARROW_W = 32
) (
  input  logic [IDX_W+2:0]  selector_i,
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [1:0]        rpl_o
);
  localparam int PAD_W = ADDR_W - IDX_W - 3;

  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] scaled_idx;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    tbl_base   = selector_i[2] ? ldt_base_i : gdt_base_i;
    scaled_idx = {{PAD_W{1'b0}}, selector_i[IDX_W+2:3], 3'b000};
    sum        = tbl_base + scaled_idx;
    desc_addr_o = mode64_i ? sum : {{(ADDR_W-NARROW_W){1'b0}}, sum[NARROW_W-1:0]};
    rpl_o      = selector_i[1:0];
  end

endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              mode64_i,
  output logic              idle_o,
  output logic              done_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic [WORD_W-1:0] lo_word_o,
  output logic [WORD_W-1:0] hi_word_o
);
  localparam int STEP = WORD_W / 8;

  fetch_state_e      state_q;
  logic              issued_q;
  logic [WORD_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] hi_addr;

  always_comb begin
    hi_addr = desc_addr_i + ADDR_W'(STEP);
    if (!mode64_i) hi_addr = {{(ADDR_W-32){1'b0}}, hi_addr[31:0]};
    mem_req_valid_o = ((state_q == ST_READ_LO) || (state_q == ST_READ_HI)) && !issued_q;
    mem_req_addr_o  = (state_q == ST_READ_HI) ? hi_addr : desc_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_READ_LO;
          issued_q <= 1'b0;
        end
        ST_READ_LO: begin
          if (mem_req_valid_o && mem_req_ready_i) issued_q <= 1'b1;
          if (issued_q && mem_rsp_valid_i) begin
            lo_q     <= mem_rsp_data_i;
            issued_q <= 1'b0;
            state_q  <= ST_READ_HI;
          end
        end
        ST_READ_HI: begin
          if (mem_req_valid_o && mem_req_ready_i) issued_q <= 1'b1;
          if (issued_q && mem_rsp_valid_i) begin
            hi_q     <= mem_rsp_data_i;
            issued_q <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign lo_word_o = lo_q;
  assign hi_word_o = hi_q;

  // R10: result strobe lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: strobe only follows returned data
  assert_done_after_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rsp_valid_i));
  // R11: stalled request holds
  assert_req_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  // R3: second read sits 4 bytes above the first
  assert_hi_follows_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && $past(mem_rsp_valid_i)) |->
      (mem_req_addr_o[31:0] == $past(mem_req_addr_o[31:0]) + 32'd4));

endmodule

// File: rtl/seg_lin_calc.sv
module seg_lin_calc
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CANON_W = 48
) (
  input  logic [31:0]       lo_word_i,
  input  logic [31:0]       hi_word_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              mode64_i,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              fault_o
);
  localparam int TOP_W = ADDR_W - CANON_W + 1;

  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] sum;
  logic [TOP_W-1:0]  top_bits;
  logic              canonical;

  always_comb begin
    base_ext   = {{(ADDR_W-32){1'b0}}, seg_base(lo_word_i, hi_word_i)};
    sum        = base_ext + offset_i;
    lin_addr_o = mode64_i ? sum : {{(ADDR_W-32){1'b0}}, sum[31:0]};
    top_bits   = lin_addr_o[ADDR_W-1:CANON_W-1];
    canonical  = (&top_bits) || !(|top_bits);
    fault_o    = mode64_i && !canonical;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W  = 64,
  parameter int SEL_W   = 16,
  parameter int WORD_W  = 32,
  parameter int CANON_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEL_W-1:0]  selector_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              fault_o,
  output logic [1:0]        rpl_o
);
  localparam int IDX_W = SEL_W - 3;

  logic              idle, start;
  logic [ADDR_W-1:0] desc_addr_d, desc_addr_q, offset_q;
  logic [1:0]        rpl_d, rpl_q;
  logic              mode64_q;
  logic [WORD_W-1:0] lo_word, hi_word;

  assign req_ready_o = idle;
  assign start       = req_valid_i && idle;

  seg_sel_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NARROW_W(32)) i_dec (
    .selector_i (selector_i),
    .mode64_i   (mode64_i),
    .gdt_base_i (gdt_base_i),
    .ldt_base_i (ldt_base_i),
    .desc_addr_o(desc_addr_d),
    .rpl_o      (rpl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_addr_q <= '0;
      offset_q    <= '0;
      rpl_q       <= '0;
      mode64_q    <= 1'b0;
    end else if (start) begin
      desc_addr_q <= desc_addr_d;
      offset_q    <= offset_i;
      rpl_q       <= rpl_d;
      mode64_q    <= mode64_i;
    end
  end

  seg_desc_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_fetch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .desc_addr_i    (desc_addr_q),
    .mode64_i       (mode64_q),
    .idle_o         (idle),
    .done_o         (done_o),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .lo_word_o      (lo_word),
    .hi_word_o      (hi_word)
  );

  seg_lin_calc #(.ADDR_W(ADDR_W), .CANON_W(CANON_W)) i_calc (
    .lo_word_i (lo_word),
    .hi_word_i (hi_word),
    .offset_i  (offset_q),
    .mode64_i  (mode64_q),
    .lin_addr_o(lin_addr_o),
    .fault_o   (fault_o)
  );

  assign phys_addr_o = lin_addr_o;
  assign rpl_o       = rpl_q;

endmodule

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] selector_i = '0;
  logic [63:0] offset_i = '0;
  logic        mode64_i = 1'b0;
  logic [63:0] gdt_base_i = '0;
  logic [63:0] ldt_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b1;
  logic [63:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        done_o;
  logic [63:0] lin_addr_o, phys_addr_o;
  logic        fault_o;
  logic [1:0]  rpl_o;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  logic [31:0] mem_q [logic [63:0]];
  logic [63:0] req_log [0:255];
  int req_cnt = 0;

  always #2 clk_i = ~clk_i;

  seg_xlate i_seg_xlate (.*);

  // memory model: one-cycle response after each accepted read
  always @(posedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    mem_req_ready_i <= stall_mode ? ~mem_req_ready_i : 1'b1;
    if (mem_req_valid_o && mem_req_ready_i) begin
      mem_rsp_valid_i <= 1'b1;
      mem_rsp_data_i  <= mem_q.exists(mem_req_addr_o) ? mem_q[mem_req_addr_o] : 32'hDEAD_BEEF;
      req_log[req_cnt[7:0]] <= mem_req_addr_o;
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  task automatic run_xlate(input logic [15:0] sel, input logic [63:0] off, input bit m64,
                           input logic [31:0] lo_w, input logic [31:0] hi_w, input bit poke_busy);
    logic [63:0] tbl, daddr, a4, base, lin;
    bit flt;
    int start_idx, wait_cnt;
    tbl   = sel[2] ? ldt_base_i : gdt_base_i;
    daddr = tbl + {48'd0, sel[15:3], 3'b000};
    a4    = daddr + 64'd4;
    if (!m64) begin
      daddr = {32'd0, daddr[31:0]};
      a4    = {32'd0, a4[31:0]};
    end
    mem_q[daddr] = lo_w;
    mem_q[a4]    = hi_w;
    base = {32'd0, hi_w[31:24], hi_w[7:0], lo_w[31:16]};
    lin  = m64 ? base + off : {32'd0, base[31:0] + off[31:0]};
    flt  = m64 && !((&lin[63:47]) || !(|lin[63:47]));
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10 ready while idle", {63'd0, req_ready_o}, 64'd1);
    start_idx = req_cnt;
    selector_i = sel; offset_i = off; mode64_i = m64; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R10 not ready while busy", {63'd0, req_ready_o}, 64'd0);
    if (poke_busy) begin
      // ignored request: different selector and offset while busy
      selector_i = ~sel; offset_i = ~off; req_valid_i = 1'b1;
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    wait_cnt = 0;
    while (!done_o && wait_cnt < 200) begin
      @(negedge clk_i);
      wait_cnt++;
    end
    chk(done_o == 1'b1, "R10 done seen", {63'd0, done_o}, 64'd1);
    chk(lin_addr_o == lin, m64 ? "R6 linear 64-bit" : "R5 linear 32-bit", lin_addr_o, lin);
    chk(phys_addr_o == lin, "R8 physical equals linear", phys_addr_o, lin);
    chk(fault_o == flt, "R7 canonical fault", {63'd0, fault_o}, {63'd0, flt});
    chk(rpl_o == sel[1:0], "R9 rpl carried", {62'd0, rpl_o}, {62'd0, sel[1:0]});
    chk(req_cnt - start_idx == 2, "R3 two reads", 64'(req_cnt - start_idx), 64'd2);
    chk(req_log[start_idx[7:0]] == daddr, "R2 descriptor address", req_log[start_idx[7:0]], daddr);
    chk(req_log[8'(start_idx + 1)] == a4, "R3 second read address", req_log[8'(start_idx + 1)], a4);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 done one cycle", {63'd0, done_o}, 64'd0);
    chk(req_ready_o == 1'b1, "R10 ready after done", {63'd0, req_ready_o}, 64'd1);
    chk(lin_addr_o == lin, "R5 result held", lin_addr_o, lin);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready", {63'd0, req_ready_o}, 64'd1);
    chk(done_o == 1'b0, "R1 done low", {63'd0, done_o}, 64'd0);
    chk(mem_req_valid_o == 1'b0, "R1 no read", {63'd0, mem_req_valid_o}, 64'd0);
    chk(fault_o == 1'b0, "R1 fault low", {63'd0, fault_o}, 64'd0);
    chk(lin_addr_o == 64'd0, "R1 linear zero", lin_addr_o, 64'd0);
  endtask

  task automatic test_tables_32();
    // R2 R4 R5: same index, both tables, distinct field bytes
    gdt_base_i = 64'h0000_0000_0001_0000;
    ldt_base_i = 64'h0000_0000_0002_0000;
    run_xlate(16'h0028, 64'h0000_0000_0000_0100, 1'b0, 32'hA1B2_C3D4, 32'h5566_7788, 1'b0);
    run_xlate(16'h002C, 64'h0000_0000_0000_0100, 1'b0, 32'h1122_3344, 32'hAABB_CCDD, 1'b0);
  endtask

  task automatic test_wrap_32();
    // R5: high offset bits ignored, 32-bit sum wraps; R2: address wraps
    gdt_base_i = 64'h0000_0000_FFFF_FFF8;
    run_xlate(16'h0008, 64'hFFFF_0000_F000_0000, 1'b0, 32'h0000_0000, 32'h2000_0000, 1'b1);
    // R7: no fault in 32-bit mode whatever the high offset bits
    run_xlate(16'h0000, 64'h8000_0000_0000_0000, 1'b0, 32'h1234_0000, 32'h0000_0000, 1'b0);
  endtask

  task automatic test_canon_64();
    gdt_base_i = 64'h0000_1000_0000_0000;
    // R6: just below 2^47, canonical
    run_xlate(16'h0010, 64'h0000_7FFF_FFFF_FF00, 1'b1, 32'h00FF_0000, 32'h0000_0000, 1'b0);
    // R7: reaches 2^47, fault
    run_xlate(16'h0018, 64'h0000_7FFF_FFFF_FF00, 1'b1, 32'h0100_0000, 32'h0000_0000, 1'b0);
    // R7: upper canonical half, no fault
    run_xlate(16'h0020, 64'hFFFF_8000_0000_0000, 1'b1, 32'h5678_0000, 32'h9A00_00BC, 1'b0);
    // R6: 64-bit sum carries past 32 bits
    run_xlate(16'h0030, 64'h0000_0000_FFFF_FFFF, 1'b1, 32'h0001_0000, 32'h0000_0000, 1'b0);
  endtask

  task automatic test_stall_max();
    // R11: ready toggles; R9: max index with rpl 3
    stall_mode = 1'b1;
    ldt_base_i = 64'h0000_0000_4000_0000;
    run_xlate(16'hFFFF, 64'h0000_0000_0000_0010, 1'b1, 32'hCAFE_0000, 32'h1200_0034, 1'b1);
    stall_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    test_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_tables_32();
    test_wrap_32();
    test_canon_64();
    test_stall_max();
    repeat (4) @(negedge clk_i);
    finish_run();
  end

endmodule